// File: doc/BRIEF.md
# Power-Management I/O Window Decoder and SCI Generator

This block sits inside the power-management function of a system controller. It keeps three configuration dwords: a window base, a window control word and a power-management base word. From the first two it places a 64-byte I/O window anywhere in a 16-bit I/O space on a 64-byte boundary. For each I/O address presented, it reports whether the address falls inside that window and, if so, its byte offset within it.

The same block turns the PM1 event status and enable words into a level-sensitive system control interrupt (SCI). Only four event sources can raise the SCI. The block also drives an arm request for the PM timer overflow. The PM1 registers and the timer counter are held outside the block and arrive here as plain inputs.

Top module: `pm_io_sci_top`

## Requirements
- R1: The window base is bits [15:0] of the configuration dword at offset 0x40, ANDed with 0xFFC0. Bits [31:16] and [5:0] of that dword have no effect on decoding.
- R2: While the window is enabled, `io_hit` is high in the same cycle for every `io_addr` from base to base+63, and `io_offset` equals `io_addr` minus base. Every other address gives `io_hit` low.
- R3: The window is enabled only while bit 0 of the configuration dword at offset 0x80 is 1. That bit is 0 after reset, so no address hits until it is written.
- R4: A configuration write changes the stored dword on the clock edge where `cfg_we` is high. Only the byte lanes whose `cfg_be` bit is set are written, and `cfg_addr[1:0]` are ignored. `cfg_rdata` returns the dword selected by `cfg_addr` in the same cycle. Offsets other than 0x40, 0x48 and 0x80 read as zero and ignore writes.
- R5: After reset the dword at 0x48 reads 0x00000001, and the dwords at 0x40 and 0x80 read 0x00000000.
- R6: `sci_level` is high in the cycle after any of PM1 bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC alarm) has both its status and its enable bit set. It is low in the cycle after none does.
- R7: PM1 bits other than 0, 5, 8 and 10 never raise `sci_level`, even when both their status and enable bits are set.
- R8: `tmr_arm` is high in the cycle after enable bit 0 is 1 and status bit 0 is 0, and low in the cycle after any other combination.
- R9: During and right after reset, `sci_level` and `tmr_arm` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset; selects the dword for both write and read |
| cfg_be | input | 4 | Byte-lane enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the dword at `cfg_addr` |
| io_addr | input | 16 | I/O address to decode |
| io_hit | output | 1 | Address is inside the enabled window |
| io_offset | output | 6 | Offset of the address within the window |
| pm1_sts | input | 16 | PM1 event status word |
| pm1_en | input | 16 | PM1 event enable word |
| sci_level | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Request to arm the timer overflow interrupt |

## Verification
`io_hit`, `io_offset` and `cfg_rdata` are combinational from `io_addr`, `cfg_addr` and the stored configuration. A configuration write therefore shows on them in the first cycle after its clock edge. `sci_level` and `tmr_arm` are registered and follow the PM1 inputs one edge later. The bench drives inputs shortly after each rising edge. Its behavioural model updates on the same edge the design does, and both are compared at the falling edge, where the combinational results and the one-cycle registered results are all settled. The directed checks sample right after the drive for decode and readback, and after one further edge for SCI and timer arming.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // Configuration dword offsets (byte offsets in configuration space)
    localparam int CFG_OFF_WIN_BASE = 8'h40;
    localparam int CFG_OFF_PM_BASE  = 8'h48;
    localparam int CFG_OFF_WIN_CTL  = 8'h80;

    // Reset contents of the three dwords
    localparam logic [31:0] RST_WIN_BASE = 32'h0000_0000;
    localparam logic [31:0] RST_PM_BASE  = 32'h0000_0001;
    localparam logic [31:0] RST_WIN_CTL  = 32'h0000_0000;

    // Bit of the control dword that opens the window
    localparam int WIN_EN_BIT = 0;

    // PM1 event bit positions that may raise the SCI
    localparam int EVB_TIMER  = 0;
    localparam int EVB_GLOCK  = 5;
    localparam int EVB_PWRBTN = 8;
    localparam int EVB_RTC    = 10;

    typedef struct packed {
        logic        sci;
        logic        arm;
    } pm_irq_t;

    // Mask of PM1 bits that can contribute to the SCI
    function automatic logic [15:0] sci_src_mask();
        logic [15:0] m;
        m = '0;
        m[EVB_TIMER]  = 1'b1;
        m[EVB_GLOCK]  = 1'b1;
        m[EVB_PWRBTN] = 1'b1;
        m[EVB_RTC]    = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_pkg::*;
#(
    parameter int CFG_AW = 8,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     win_base_q,
    output logic [DW-1:0]     win_ctl_q
);
    localparam int LANES = DW / 8;
    localparam int WA    = CFG_AW - 2;

    logic [WA-1:0] widx;
    logic          sel_base, sel_pmb, sel_ctl;
    logic [DW-1:0] pm_base_q;
    logic          unused_lsb;

    assign widx       = addr[CFG_AW-1:2];
    assign unused_lsb = ^addr[1:0];
    assign sel_base   = (widx == WA'(CFG_OFF_WIN_BASE >> 2));
    assign sel_pmb    = (widx == WA'(CFG_OFF_PM_BASE  >> 2));
    assign sel_ctl    = (widx == WA'(CFG_OFF_WIN_CTL  >> 2));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] base_b, pmb_b, ctl_b;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_b <= RST_WIN_BASE[g*8 +: 8];
                pmb_b  <= RST_PM_BASE[g*8 +: 8];
                ctl_b  <= RST_WIN_CTL[g*8 +: 8];
            end else if (wr_en && be[g]) begin
                if (sel_base) base_b <= wdata[g*8 +: 8];
                if (sel_pmb)  pmb_b  <= wdata[g*8 +: 8];
                if (sel_ctl)  ctl_b  <= wdata[g*8 +: 8];
            end
        end
        assign win_base_q[g*8 +: 8] = base_b;
        assign pm_base_q[g*8 +: 8]  = pmb_b;
        assign win_ctl_q[g*8 +: 8]  = ctl_b;
    end

    always_comb begin
        rdata = '0;
        if (sel_base)     rdata = win_base_q;
        else if (sel_pmb) rdata = pm_base_q;
        else if (sel_ctl) rdata = win_ctl_q;
    end

    // R5: PM base dword holds its reset value in the first cycle after reset
    assert_pmbase_reset_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pm_base_q == DW'(RST_PM_BASE)));

    // R4: a write to an unselected dword leaves the base unchanged
    assert_base_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel_base) |=> $stable(win_base_q));

endmodule

// File: rtl/pm_io_window.sv
module pm_io_window #(
    parameter int IO_AW   = 16,
    parameter int WIN_LG2 = 6
) (
    input  logic               en,
    input  logic [IO_AW-1:0]   base_raw,
    input  logic [IO_AW-1:0]   addr,
    output logic               hit,
    output logic [WIN_LG2-1:0] offset
);
    localparam int TAG_W = IO_AW - WIN_LG2;

    logic [TAG_W-1:0] base_tag;
    logic [TAG_W-1:0] addr_tag;
    logic             unused_base_low;

    // Alignment mask: low WIN_LG2 bits of the base are discarded
    assign base_tag        = base_raw[IO_AW-1:WIN_LG2];
    assign unused_base_low = ^base_raw[WIN_LG2-1:0];
    assign addr_tag        = addr[IO_AW-1:WIN_LG2];

    assign hit    = en && (addr_tag == base_tag);
    assign offset = addr[WIN_LG2-1:0];

endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
    import pm_pkg::*;
#(
    parameter int PM1_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PM1_W-1:0] sts,
    input  logic [PM1_W-1:0] en,
    output pm_irq_t          irq_q
);
    localparam logic [PM1_W-1:0] SRC_MASK = PM1_W'(sci_src_mask());

    pm_irq_t irq_d;

    always_comb begin
        irq_d.sci = |(sts & en & SRC_MASK);
        irq_d.arm = en[EVB_TIMER] & ~sts[EVB_TIMER];
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= irq_d;
    end

    // R6: each qualifying source raises the SCI on the next cycle
    assert_sci_timer_R6: assert property (@(posedge clk) disable iff (rst)
        (sts[EVB_TIMER] && en[EVB_TIMER]) |=> irq_q.sci);
    assert_sci_rtc_R6: assert property (@(posedge clk) disable iff (rst)
        (sts[EVB_RTC] && en[EVB_RTC]) |=> irq_q.sci);

    // R7: with all four sources quiet the SCI drops regardless of other bits
    assert_sci_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((sts[EVB_TIMER] & en[EVB_TIMER]) == 1'b0 &&
         (sts[EVB_GLOCK] & en[EVB_GLOCK]) == 1'b0 &&
         (sts[EVB_PWRBTN] & en[EVB_PWRBTN]) == 1'b0 &&
         (sts[EVB_RTC] & en[EVB_RTC]) == 1'b0) |=> !irq_q.sci);

    // R8: a pending timer status blocks arming
    assert_arm_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        sts[EVB_TIMER] |=> !irq_q.arm);
    assert_arm_set_R8: assert property (@(posedge clk) disable iff (rst)
        (en[EVB_TIMER] && !sts[EVB_TIMER]) |=> irq_q.arm);

    // R9: outputs are low right after reset
    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_q.sci && !irq_q.arm));

endmodule

// File: rtl/pm_io_sci_top.sv
module pm_io_sci_top
    import pm_pkg::*;
#(
    parameter int CFG_AW  = 8,
    parameter int DW      = 32,
    parameter int IO_AW   = 16,
    parameter int WIN_LG2 = 6,
    parameter int PM1_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [DW/8-1:0]    cfg_be,
    input  logic [DW-1:0]      cfg_wdata,
    output logic [DW-1:0]      cfg_rdata,
    input  logic [IO_AW-1:0]   io_addr,
    output logic               io_hit,
    output logic [WIN_LG2-1:0] io_offset,
    input  logic [PM1_W-1:0]   pm1_sts,
    input  logic [PM1_W-1:0]   pm1_en,
    output logic               sci_level,
    output logic               tmr_arm
);
    logic [DW-1:0] win_base_q;
    logic [DW-1:0] win_ctl_q;
    pm_irq_t       irq;
    logic          unused_cfg;

    assign unused_cfg = ^{win_base_q[DW-1:IO_AW], win_ctl_q[DW-1:1]};

    pm_cfg_regs #(.CFG_AW(CFG_AW), .DW(DW)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we),
        .addr       (cfg_addr),
        .be         (cfg_be),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .win_base_q (win_base_q),
        .win_ctl_q  (win_ctl_q)
    );

    pm_io_window #(.IO_AW(IO_AW), .WIN_LG2(WIN_LG2)) u_win (
        .en       (win_ctl_q[WIN_EN_BIT]),
        .base_raw (win_base_q[IO_AW-1:0]),
        .addr     (io_addr),
        .hit      (io_hit),
        .offset   (io_offset)
    );

    pm_sci_gen #(.PM1_W(PM1_W)) u_sci (
        .clk   (clk),
        .rst   (rst),
        .sts   (pm1_sts),
        .en    (pm1_en),
        .irq_q (irq)
    );

    assign sci_level = irq.sci;
    assign tmr_arm   = irq.arm;

    // R3: window closed in the first cycle after reset
    assert_win_closed_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !io_hit);

    // R3: clearing the enable bit closes the window on the next cycle
    assert_win_disable_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_be[0] && !cfg_wdata[WIN_EN_BIT] &&
         cfg_addr[CFG_AW-1:2] == (CFG_AW-2)'(CFG_OFF_WIN_CTL >> 2)) |=> !io_hit);

endmodule

// File: tb/tb_pm_io_sci_top.sv
module tb_pm_io_sci_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_hit;
    logic [5:0]  io_offset;
    logic [15:0] pm1_sts = '0;
    logic [15:0] pm1_en = '0;
    logic        sci_level;
    logic        tmr_arm;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_io_sci_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_hit(io_hit), .io_offset(io_offset),
        .pm1_sts(pm1_sts), .pm1_en(pm1_en),
        .sci_level(sci_level), .tmr_arm(tmr_arm)
    );

    // ---------------- behavioural reference ----------------
    int unsigned m_base, m_pmb, m_ctl;
    bit m_sci, m_arm;
    int src_bits[4] = '{0, 5, 8, 10};

    always @(posedge clk) begin
        if (rst) begin
            m_base <= 0; m_pmb <= 1; m_ctl <= 0; m_sci <= 0; m_arm <= 0;
        end else begin
            bit s;
            s = 0;
            foreach (src_bits[i]) if (pm1_sts[src_bits[i]] && pm1_en[src_bits[i]]) s = 1;
            m_sci <= s;
            m_arm <= pm1_en[0] && !pm1_sts[0];
            if (cfg_we) begin
                int unsigned nb, np, nc;
                nb = m_base; np = m_pmb; nc = m_ctl;
                for (int l = 0; l < 4; l++) begin
                    if (cfg_be[l]) begin
                        int unsigned byt;
                        byt = (cfg_wdata >> (8*l)) & 32'hFF;
                        case (cfg_addr / 4)
                            8'h40/4: nb = (nb & ~(32'hFF << (8*l))) | (byt << (8*l));
                            8'h48/4: np = (np & ~(32'hFF << (8*l))) | (byt << (8*l));
                            8'h80/4: nc = (nc & ~(32'hFF << (8*l))) | (byt << (8*l));
                            default: ;
                        endcase
                    end
                end
                m_base <= nb; m_pmb <= np; m_ctl <= nc;
            end
        end
    end

    function automatic int unsigned exp_rdata();
        case (cfg_addr / 4)
            8'h40/4: return m_base;
            8'h48/4: return m_pmb;
            8'h80/4: return m_ctl;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_diff();
        return int'(io_addr) - int'(m_base & 32'hFFC0);
    endfunction

    function automatic bit exp_hit();
        int d;
        d = exp_diff();
        return (m_ctl & 1) != 0 && d >= 0 && d < 64;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(io_hit == exp_hit(), "R2 hit", io_hit, exp_hit());
            if (exp_hit()) chk(int'(io_offset) == exp_diff(), "R2 offset", io_offset, exp_diff());
            chk(sci_level == m_sci, "R6 sci", sci_level, m_sci);
            chk(tmr_arm == m_arm, "R8 arm", tmr_arm, m_arm);
            chk(cfg_rdata == exp_rdata(), "R4 rdata", cfg_rdata, exp_rdata());
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
        cfg_we = 1; cfg_addr = a; cfg_be = b; cfg_wdata = d;
        tick(1);
        cfg_we = 0; cfg_be = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        // reset state: sci/arm during reset
        chk(sci_level == 0 && tmr_arm == 0, "R9 in reset", {sci_level, tmr_arm}, 0);
        rst = 0;
        cfg_addr = 8'h48; io_addr = 16'h0000;
        #1;
        chk(cfg_rdata == 32'h1, "R5 pm base reset", cfg_rdata, 1);
        chk(io_hit == 0, "R3 closed after reset", io_hit, 0);
        chk(sci_level == 0 && tmr_arm == 0, "R9 after reset", {sci_level, tmr_arm}, 0);
        cfg_addr = 8'h40; #1;
        chk(cfg_rdata == 0, "R5 win base reset", cfg_rdata, 0);
        cfg_addr = 8'h80; #1;
        chk(cfg_rdata == 0, "R5 win ctl reset", cfg_rdata, 0);

        // base with junk in upper and low bits, window still closed
        wr(8'h40, 4'hF, 32'hABCD_1234);
        io_addr = 16'h1200; #1;
        chk(io_hit == 0, "R3 not enabled", io_hit, 0);
        wr(8'h83, 4'h1, 32'h0000_0001);     // low address bits ignored
        io_addr = 16'h1200; #1;
        chk(io_hit == 1 && io_offset == 0, "R1 aligned base", {io_hit, io_offset}, 7'h40);
        io_addr = 16'h123F; #1;
        chk(io_hit == 1 && io_offset == 63, "R2 top byte", {io_hit, io_offset}, 7'h7F);
        io_addr = 16'h1240; #1;
        chk(io_hit == 0, "R2 past end", io_hit, 0);
        io_addr = 16'h11FF; #1;
        chk(io_hit == 0, "R2 below base", io_hit, 0);

        // byte-lane write changes only lane 1
        wr(8'h41, 4'b0010, 32'hFFFF_56FF);
        cfg_addr = 8'h40; io_addr = 16'h5611; #1;
        chk(cfg_rdata == 32'hABCD_5634, "R4 lane write", cfg_rdata, 32'hABCD_5634);
        chk(io_hit == 1 && io_offset == 6'h11, "R1 new base", {io_hit, io_offset}, 7'h51);

        // unmapped offset
        wr(8'h44, 4'hF, 32'hDEAD_BEEF);
        cfg_addr = 8'h44; #1;
        chk(cfg_rdata == 0, "R4 unmapped", cfg_rdata, 0);

        // disable window
        wr(8'h80, 4'h1, 32'h0);
        io_addr = 16'h5611; #1;
        chk(io_hit == 0, "R3 disabled", io_hit, 0);
        wr(8'h80, 4'h1, 32'h1);

        // non-source bits only
        pm1_sts = ~16'h0521; pm1_en = ~16'h0521; tick(1);
        chk(sci_level == 0, "R7 other bits", sci_level, 0);
        // each source alone
        foreach (src_bits[i]) begin
            pm1_sts = 16'(1 << src_bits[i]); pm1_en = 16'(1 << src_bits[i]); tick(1);
            chk(sci_level == 1, "R6 single source", sci_level, 1);
        end
        pm1_sts = 16'h0400; pm1_en = 16'hFBFF; tick(1);
        chk(sci_level == 0, "R6 status without enable", sci_level, 0);
        // timer arming
        pm1_sts = 0; pm1_en = 16'h0001; tick(1);
        chk(tmr_arm == 1, "R8 armed", tmr_arm, 1);
        pm1_sts = 16'h0001; tick(1);
        chk(tmr_arm == 0, "R8 status pending", tmr_arm, 0);
        pm1_en = 0; pm1_sts = 0; tick(1);
        chk(tmr_arm == 0, "R8 not enabled", tmr_arm, 0);

        // random phase checked by the model every cycle
        for (int k = 0; k < 600; k++) begin
            int sel;
            pm1_sts = 16'($urandom);
            pm1_en  = 16'($urandom);
            io_addr = 16'((m_base & 32'hFFC0) - 8 + ($urandom % 80));
            sel = $urandom % 8;
            if (sel == 0) begin
                int a;
                a = $urandom % 4;
                cfg_we = 1;
                cfg_addr = (a == 0) ? 8'h40 : (a == 1) ? 8'h80 : (a == 2) ? 8'h48 : 8'h4C;
                cfg_be = 4'($urandom);
                cfg_wdata = $urandom;
                if (a == 1) cfg_wdata[0] = ($urandom % 4) != 0;
            end else begin
                cfg_we = 0;
                cfg_addr = 8'($urandom);
            end
            tick(1);
        end
        cfg_we = 0;
        tick(2);
        finish_run();
    end

endmodule